// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Sequencer

This block produces the array-side timing of a synchronous burst read. An 8-bit settings word, loaded through a write strobe, selects asynchronous or burst operation, whether the ready output leads the data by one burst-clock edge, which transition of the burst clock is active, and the burst length with its wrap rule. The burst clock `bclk_i` is sampled in the `clk_i` domain. Its active transitions are turned into single-cycle pulses that drive the sequencer.

While the address-valid strobe `avd_ni` is low, the starting word address is captured and the latency count is cleared. After the strobe returns high, the block counts active burst-clock edges. When the programmed latency is reached, `data_valid_o` goes high. Each later active edge then steps `arr_addr_o`, which feeds an external array read port. In asynchronous mode no sequencing takes place: the captured address is presented as is and ready stays high.

Settings word layout (bit 7 down to 0): `[7]` async_mode, `[6]` rdy_with_data, `[5]` rise_active, `[4:3]` wrap_len, `[2:0]` lat_code.

Top module: `burst_read_seq`

## Requirements
- R1: After reset the settings word is 8'hE0 (asynchronous, ready with data, rising edge active, continuous, latency code 0). The outputs are `arr_addr_o`=0, `data_valid_o`=0 and `rdy_o`=1.
- R2: With async_mode=1, an `avd_ni` low cycle captures `addr_i` into `arr_addr_o`. Burst-clock edges then leave the address unchanged, `data_valid_o` stays 0 and `rdy_o` stays 1.
- R3: With async_mode=0 and lat_code n (0..5), `data_valid_o` first goes high on the (n+2)th active burst-clock edge after `avd_ni` returns high. It changes one `clk_i` cycle after the edge is sampled.
- R4: lat_code values 6 and 7 behave exactly like 5: data is valid from the 7th active edge.
- R5: With rdy_with_data=1, `rdy_o` equals `data_valid_o` in burst mode. With rdy_with_data=0, `rdy_o` rises one active edge earlier, on the (n+1)th edge.
- R6: rise_active=1 makes 0-to-1 transitions of `bclk_i` active. rise_active=0 makes 1-to-0 transitions active. Inactive transitions change no output.
- R7: With wrap_len=00 (continuous), each active edge after the first valid one adds 1 to the whole address. The address rolls over from all ones to 0.
- R8: wrap_len 01, 10 and 11 select 8-, 16- and 32-word bursts. The low 3, 4 or 5 address bits step modulo the burst length and the upper bits stay fixed.
- R9: An `avd_ni` low cycle during a burst clears `data_valid_o` and `rdy_o` (in burst mode), loads the new address and restarts the latency count.
- R10: A cycle with `cfg_we_i`=1 loads all 8 bits of `cfg_data_i`. The new settings govern the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Settings write strobe |
| cfg_data_i | input | 8 | Settings word |
| bclk_i | input | 1 | Burst clock, sampled in the clk_i domain |
| avd_ni | input | 1 | Address-valid strobe, active low |
| addr_i | input | 21 | Starting word address |
| arr_addr_o | output | 21 | Word address to the array read port |
| data_valid_o | output | 1 | Array data valid |
| rdy_o | output | 1 | Ready output |

## Verification
The bench sweeps every latency code, including the two reserved ones. A design that is off by one edge, or that decodes codes 6 and 7 literally, shows `data_valid_o` in the wrong half-period. Bursts start near the end of a wrap window and at the top of the address space. A design that carries into the upper bits, or wraps instead of rolling over, gives the wrong `arr_addr_o` on those steps. The bench also runs on falling edges, runs with early ready, and restarts a burst with a new strobe partway through. These catch a design that steps on both transitions, asserts ready on the wrong edge, or keeps counting across a restart.

// File: rtl/brs_pkg.sv
package brs_pkg;
  localparam int ADDR_W  = 21;
  localparam int LAT_W   = 3;
  localparam int CNT_W   = 3;
  localparam int MAX_LAT = 5;

  typedef struct packed {
    logic             async_mode;
    logic             rdy_with_data;
    logic             rise_active;
    logic [1:0]       wrap_len;
    logic [LAT_W-1:0] lat_code;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
  localparam cfg_t CFG_RST = '{async_mode: 1'b1, rdy_with_data: 1'b1,
                               rise_active: 1'b1, wrap_len: 2'b00,
                               lat_code: '0};
endpackage

// File: rtl/brs_cfg_reg.sv
module brs_cfg_reg
  import brs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] data_i,
  output cfg_t             cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_o <= CFG_RST;
    else if (we_i) cfg_o <= cfg_t'(data_i);
  end

  assert_cfg_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cfg_o == cfg_t'($past(data_i))));
endmodule

// File: rtl/brs_edge_det.sv
module brs_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic rise_sel_i,
  output logic act_o
);
  logic bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_q <= 1'b0;
    else         bclk_q <= bclk_i;
  end

  always_comb begin
    if (rise_sel_i) act_o = bclk_i & ~bclk_q;
    else            act_o = ~bclk_i & bclk_q;
  end

  // same-direction transitions cannot sit in adjacent cycles
  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o && $stable(rise_sel_i)) |=> !act_o);
endmodule

// File: rtl/brs_lat_ctr.sv
module brs_lat_ctr
  import brs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             avd_ni,
  input  logic             act_i,
  input  logic             sync_en_i,
  input  logic [LAT_W-1:0] lat_code_i,
  output logic             valid_o,
  output logic             early_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [CNT_W:0]   lat_eff, thr_valid, thr_early;

  always_comb begin
    lat_eff   = (lat_code_i > LAT_W'(MAX_LAT)) ? (CNT_W+1)'(MAX_LAT)
                                                 : (CNT_W+1)'(lat_code_i);
    thr_valid = lat_eff + (CNT_W+1)'(2);
    thr_early = lat_eff + (CNT_W+1)'(1);
    cnt_nxt   = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_o <= 1'b0;
      early_o <= 1'b0;
    end else if (!avd_ni) begin
      cnt_q   <= '0;
      valid_o <= 1'b0;
      early_o <= 1'b0;
    end else if (sync_en_i && act_i) begin
      cnt_q   <= cnt_nxt;
      valid_o <= ({1'b0, cnt_nxt} >= thr_valid);
      early_o <= ({1'b0, cnt_nxt} >= thr_early);
    end
  end

  assert_restart_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !avd_ni |=> (!valid_o && !early_o));
  assert_valid_on_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(act_i));
  assert_early_leads_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> early_o);
endmodule

// File: rtl/brs_addr_gen.sv
module brs_addr_gen
  import brs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              avd_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              step_i,
  input  logic [1:0]        wrap_len_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] mask, addr_nxt;

  always_comb begin
    unique case (wrap_len_i)
      2'b01:   mask = ADDR_W'(7);
      2'b10:   mask = ADDR_W'(15);
      2'b11:   mask = ADDR_W'(31);
      default: mask = '1;
    endcase
    addr_nxt = (addr_o & ~mask) | ((addr_o + 1'b1) & mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_o <= '0;
    else if (!avd_ni) addr_o <= addr_i;
    else if (step_i)  addr_o <= addr_nxt;
  end

  assert_upper_fixed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avd_ni && step_i && wrap_len_i != 2'b00) |=>
      ((addr_o & ~$past(mask)) == ($past(addr_o) & ~$past(mask))));
  assert_no_step_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avd_ni && !step_i) |=> $stable(addr_o));
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import brs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_data_i,
  input  logic              bclk_i,
  input  logic              avd_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic              data_valid_o,
  output logic              rdy_o
);
  cfg_t cfg;
  logic act, sync_en, valid_q, early_q;

  brs_cfg_reg u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .data_i(cfg_data_i), .cfg_o(cfg)
  );

  brs_edge_det u_edge (
    .clk_i, .rst_ni, .bclk_i, .rise_sel_i(cfg.rise_active), .act_o(act)
  );

  assign sync_en = ~cfg.async_mode;

  brs_lat_ctr u_lat (
    .clk_i, .rst_ni, .avd_ni, .act_i(act), .sync_en_i(sync_en),
    .lat_code_i(cfg.lat_code), .valid_o(valid_q), .early_o(early_q)
  );

  brs_addr_gen u_addr (
    .clk_i, .rst_ni, .avd_ni, .addr_i,
    .step_i(sync_en & act & valid_q), .wrap_len_i(cfg.wrap_len),
    .addr_o(arr_addr_o)
  );

  assign data_valid_o = sync_en & valid_q;
  assign rdy_o        = cfg.async_mode | (cfg.rdy_with_data ? valid_q : early_q);

  assert_async_addr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.async_mode && avd_ni) |=> $stable(arr_addr_o));
endmodule

// File: tb/tb_burst_read_seq.sv
module tb_burst_read_seq;
  import brs_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cfg_we_i = 1'b0;
  logic [CFG_W-1:0]  cfg_data_i = '0;
  logic              bclk_i = 1'b0;
  logic              avd_ni = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [ADDR_W-1:0] arr_addr_o;
  logic              data_valid_o, rdy_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  burst_read_seq dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_cfg(cfg_t c);
    @(negedge clk_i); cfg_we_i = 1'b1; cfg_data_i = c;
    @(negedge clk_i); cfg_we_i = 1'b0;
  endtask

  task automatic strobe(cfg_t c, logic [ADDR_W-1:0] a, string req);
    @(negedge clk_i); avd_ni = 1'b0; addr_i = a;
    @(negedge clk_i); avd_ni = 1'b1;
    check(req, arr_addr_o, a);
    check(req, data_valid_o, 0);
    check(req, rdy_o, c.async_mode);
  endtask

  function automatic logic [ADDR_W-1:0] exp_addr(cfg_t c, logic [ADDR_W-1:0] s, int steps);
    int size;
    logic [ADDR_W-1:0] base;
    if (c.wrap_len == 2'b00) return s + ADDR_W'(steps);
    size = 8 << (c.wrap_len - 1);
    base = s - (s % size);
    return base + ADDR_W'(((s % size) + steps) % size);
  endfunction

  // toggle bclk until n active edges, checking after every transition
  task automatic run_edges(cfg_t c, logic [ADDR_W-1:0] s, int n, string req);
    int k = 0;
    int lat = (c.lat_code > 5) ? 5 : int'(c.lat_code);
    while (k < n) begin
      logic ev, er;
      int steps;
      @(negedge clk_i); bclk_i = ~bclk_i;
      if (bclk_i == c.rise_active) k++;
      @(negedge clk_i);
      if (c.async_mode) begin
        check(req, arr_addr_o, s);
        check(req, data_valid_o, 0);
        check(req, rdy_o, 1);
      end else begin
        ev = (k >= lat + 2);
        er = c.rdy_with_data ? ev : (k >= lat + 1);
        steps = ev ? k - (lat + 2) : 0;
        check(req, data_valid_o, ev);
        check(req, rdy_o, er);
        check(req, arr_addr_o, exp_addr(c, s, steps));
      end
    end
  endtask

  function automatic cfg_t mk(logic am, logic rd, logic re, logic [1:0] wl, logic [2:0] lc);
    return '{async_mode: am, rdy_with_data: rd, rise_active: re, wrap_len: wl, lat_code: lc};
  endfunction

  task automatic t_reset;
    cfg_t c = mk(1, 1, 1, 2'b00, 3'd0);
    check("R1", arr_addr_o, 0);
    check("R1", data_valid_o, 0);
    check("R1", rdy_o, 1);
    strobe(c, 21'h0ABCD, "R1");
    run_edges(c, 21'h0ABCD, 4, "R1");
  endtask

  task automatic t_async;
    cfg_t c = mk(1, 0, 0, 2'b10, 3'd1);
    write_cfg(c);
    strobe(c, 21'h1F00F, "R2");
    run_edges(c, 21'h1F00F, 6, "R2");
  endtask

  task automatic t_latency;
    for (int lc = 0; lc < 8; lc++) begin
      cfg_t c = mk(0, 1, 1, 2'b00, 3'(lc));
      write_cfg(c);
      strobe(c, 21'(100 * lc), lc > 5 ? "R4" : "R3");
      run_edges(c, 21'(100 * lc), 10, lc > 5 ? "R4" : "R3");
    end
  endtask

  task automatic t_rdy_early;
    cfg_t c = mk(0, 0, 1, 2'b00, 3'd2);
    write_cfg(c);
    strobe(c, 21'h00400, "R5");
    run_edges(c, 21'h00400, 7, "R5");
    c = mk(0, 0, 1, 2'b00, 3'd0);
    write_cfg(c);
    strobe(c, 21'h00500, "R5");
    run_edges(c, 21'h00500, 4, "R5");
  endtask

  task automatic t_falling;
    cfg_t c = mk(0, 1, 0, 2'b00, 3'd1);
    write_cfg(c);
    strobe(c, 21'h03000, "R6");
    run_edges(c, 21'h03000, 7, "R6");
  endtask

  task automatic t_rollover;
    cfg_t c = mk(0, 1, 1, 2'b00, 3'd0);
    write_cfg(c);
    strobe(c, 21'h1FFFFD, "R7");
    run_edges(c, 21'h1FFFFD, 8, "R7");
  endtask

  task automatic t_wrap;
    for (int wl = 1; wl < 4; wl++) begin
      cfg_t c = mk(0, 1, 1, 2'(wl), 3'd1);
      logic [ADDR_W-1:0] s = 21'h12345 | ADDR_W'((8 << (wl - 1)) - 3);
      write_cfg(c);
      strobe(c, s, "R8");
      run_edges(c, s, 3 + (8 << (wl - 1)) + 2, "R8");
    end
  endtask

  task automatic t_abort;
    cfg_t c = mk(0, 0, 1, 2'b01, 3'd1);
    write_cfg(c);
    strobe(c, 21'h00100, "R9");
    run_edges(c, 21'h00100, 5, "R9");
    strobe(c, 21'h0777E, "R9");
    run_edges(c, 21'h0777E, 6, "R9");
  endtask

  task automatic t_cfg_switch;
    cfg_t c = mk(0, 1, 1, 2'b11, 3'd3);
    write_cfg(c);
    strobe(c, 21'h02222, "R10");
    run_edges(c, 21'h02222, 7, "R10");
    c = mk(1, 1, 1, 2'b00, 3'd0);
    write_cfg(c);
    strobe(c, 21'h03333, "R10");
    run_edges(c, 21'h03333, 3, "R10");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_async;
    t_latency;
    t_rdy_early;
    t_falling;
    t_rollover;
    t_wrap;
    t_abort;
    t_cfg_switch;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule